// File: doc/BRIEF.md
# Two-Wire Byte Memory Slave with Region Write Protection

This block is a byte-wide memory that answers as a slave on a two-wire serial bus (SCL clock, SDA open-drain data). The master opens a transaction with a start condition and a device byte that holds a 7-bit identifier and a read/write flag. A write transaction then carries two address bytes, high byte first, followed by any number of data bytes. A read transaction returns bytes from the internal address pointer until the master declines to acknowledge one. Writes complete at bus speed, so the block has no busy state and no polling.

A 2-bit protect code, driven from a neighbouring control register, fences off the low part of the array. A data byte aimed at a fenced address is dropped and left unacknowledged. A second device on the same bus, a bank of companion registers with its own identifier, can be accessed in between. The memory ignores those transactions and keeps its address pointer, so a later current-address read resumes where the last memory access stopped.

Both bus lines are oversampled by the system clock through synchronisers. The block assumes that SCL stays high and low for several system clocks. The pin drivers, clock stretching and the companion registers lie outside the block. The block drives one output that asks the pad to pull SDA low.

Top module: `tw_mem_slave`

## Requirements
- R1: After reset the block does not pull SDA low, and the address pointer is 0, so a current-address read right after reset returns the byte at address 0. Array contents survive reset.
- R2: The device byte is sent MSB first: bits 7..1 are the identifier and bit 0 is the direction (0 = write, 1 = read). The block acknowledges the byte only when the identifier equals DEV_ID. It acknowledges by pulling SDA low during the ninth clock.
- R3: A write transaction carries two address bytes, high byte first, and both are acknowledged. Only the low ADDR_W bits of the 16-bit address are used; the rest are ignored.
- R4: A data byte written to an unprotected address is stored at the pointer and acknowledged, and then the pointer increments by one.
- R5: A read returns the byte at the pointer, MSB first, and the pointer increments after each byte. An acknowledge from the master continues the read. A non-acknowledge ends it, and the block releases SDA.
- R6: The pointer wraps from 2^ADDR_W-1 to 0, for writes and for reads.
- R7: The protect code selects the fenced region: 00 fences nothing, 01 fences addresses below one quarter of the depth, 10 fences addresses below one half, and 11 fences the whole array. A data byte aimed at a fenced address is not stored and not acknowledged, and the pointer does not move. Address bytes are still acknowledged.
- R8: A device byte with any other identifier is not acknowledged. The block then ignores the bus until the next start condition, and the pointer is unchanged.
- R9: A repeated start in the middle of a transaction begins a new device phase. A write that carries only an address, followed by a repeated start and a read, returns data from that address.
- R10: The block changes its SDA drive only while SCL is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock that oversamples the bus |
| rst_n | input | 1 | Synchronous active-low reset |
| scl_i | input | 1 | Bus clock level seen at the pad |
| sda_i | input | 1 | Bus data level seen at the pad |
| sda_pull_low | output | 1 | 1 asks the pad to pull SDA low |
| wp_sel | input | 2 | Protect code from the companion control register |

## Verification
On every cycle, the assertions check four things. SDA changes only while SCL is low. The pointer moves only on a falling SCL edge. No array write reaches a fenced address under any protect code. A device byte with a foreign identifier never draws an acknowledge. Other behaviour needs the bench's scenarios: the stored data, the order of the address bytes, the masking of the high address bits, the wrap, the pointer surviving a companion access and a reset, and the repeated-start random read.

// File: rtl/tw_mem_pkg.sv
// Package: shared phase encoding for the two-wire memory slave.
// Assumes: one transaction phase active at a time; PH_IDLE means "ignore bus until start".
package tw_mem_pkg;

    typedef enum logic [2:0] {
        PH_IDLE  = 3'd0,
        PH_DEV   = 3'd1,
        PH_AHI   = 3'd2,
        PH_ALO   = 3'd3,
        PH_WDATA = 3'd4,
        PH_RDATA = 3'd5
    } phase_t;

    localparam int unsigned BYTE_BITS = 8;

endpackage

// File: rtl/tw_line_sampler.sv
// Module: tw_line_sampler
// Synchronises SCL and SDA into the system clock domain and derives
// one-cycle events: SCL rise, SCL fall, start and stop conditions.
// Assumes: both lines stay stable for several system clocks between changes;
// lines idle high, so the synchronisers reset to 1.
module tw_line_sampler #(
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic scl_lvl,
    output logic sda_lvl,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_ev,
    output logic stop_ev
);

    logic [SYNC_STAGES-1:0] scl_ff;
    logic [SYNC_STAGES-1:0] sda_ff;
    logic                   scl_prev;
    logic                   sda_prev;

    // Purpose: shift both lines through the synchroniser chains.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            scl_ff <= '1;
            sda_ff <= '1;
        end else begin
            scl_ff <= {scl_ff[SYNC_STAGES-2:0], scl_i};
            sda_ff <= {sda_ff[SYNC_STAGES-2:0], sda_i};
        end
    end

    // Purpose: hold the previous synchronised levels for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            scl_prev <= 1'b1;
            sda_prev <= 1'b1;
        end else begin
            scl_prev <= scl_ff[SYNC_STAGES-1];
            sda_prev <= sda_ff[SYNC_STAGES-1];
        end
    end

    // Purpose: decode edges and bus conditions from current and previous levels.
    always_comb begin
        scl_lvl  = scl_ff[SYNC_STAGES-1];
        sda_lvl  = sda_ff[SYNC_STAGES-1];
        scl_rise = scl_lvl & ~scl_prev;
        scl_fall = ~scl_lvl & scl_prev;
        start_ev = scl_lvl & scl_prev & sda_prev & ~sda_lvl;
        stop_ev  = scl_lvl & scl_prev & ~sda_prev & sda_lvl;
    end

endmodule

// File: rtl/tw_protect_decode.sv
// Module: tw_protect_decode
// Maps the 2-bit protect code and the two top address bits to a
// "fenced" flag. 01 fences the lowest quarter, 10 the lowest half, 11 all.
// Assumes: the array depth is a power of two, so the fractions align with
// the top address bits.
module tw_protect_decode (
    input  logic [1:0] wp_sel,
    input  logic [1:0] addr_top,
    output logic       fenced
);

    // Purpose: compare the address quadrant against the selected region.
    always_comb begin
        unique case (wp_sel)
            2'b00:   fenced = 1'b0;
            2'b01:   fenced = (addr_top == 2'b00);
            2'b10:   fenced = ~addr_top[1];
            default: fenced = 1'b1;
        endcase
    end

endmodule

// File: rtl/tw_byte_array.sv
// Module: tw_byte_array
// Single-port synchronous byte array: one write or read address per cycle,
// read data registered (one cycle latency).
// Assumes: contents are not reset; a write and a read of the same address
// in one cycle return the old data.
module tw_byte_array #(
    parameter int unsigned ADDR_W = 9
) (
    input  logic              clk,
    input  logic              we,
    input  logic [ADDR_W-1:0] addr,
    input  logic [7:0]        wdata,
    output logic [7:0]        rdata
);

    localparam int unsigned DEPTH = 1 << ADDR_W;

    logic [7:0] cells [DEPTH];

    // Purpose: perform the write and register the read word.
    always_ff @(posedge clk) begin
        if (we) begin
            cells[addr] <= wdata;
        end
        rdata <= cells[addr];
    end

endmodule

// File: rtl/tw_mem_slave.sv
// Module: tw_mem_slave (top)
// Two-wire bus slave in front of a byte array. Decodes device, address and
// data phases, auto-increments the pointer, withholds the acknowledge on
// writes into the fenced region, and ignores foreign device identifiers.
// Assumes: SCL high and low times span several system clocks; 9 <= ADDR_W <= 15.
module tw_mem_slave
    import tw_mem_pkg::*;
#(
    parameter int unsigned ADDR_W      = 9,
    parameter logic [6:0]  DEV_ID      = 7'h50,
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       scl_i,
    input  logic       sda_i,
    output logic       sda_pull_low,
    input  logic [1:0] wp_sel
);

    localparam int unsigned HI_W    = ADDR_W - BYTE_BITS;
    localparam logic [ADDR_W-1:0] PTR_ONE = 1;
    localparam logic [3:0] CNT_LAST_DATA = 4'd8;
    localparam logic [3:0] CNT_ACK_DONE  = 4'd9;

    logic              scl_lvl, sda_lvl, scl_rise, scl_fall, start_ev, stop_ev;
    phase_t            phase;
    logic [3:0]        bit_cnt;
    logic [7:0]        rx_sh;
    logic [7:0]        tx_sh;
    logic [HI_W-1:0]   addr_hi;
    logic [ADDR_W-1:0] ptr;
    logic              rd_dir;
    logic              m_ack;
    logic              drive_low;
    logic              fenced;
    logic              mem_we;
    logic [7:0]        mem_rdata;
    logic              bus_fall;

    tw_line_sampler #(.SYNC_STAGES(SYNC_STAGES)) u_sampler (
        .clk      (clk),
        .rst_n    (rst_n),
        .scl_i    (scl_i),
        .sda_i    (sda_i),
        .scl_lvl  (scl_lvl),
        .sda_lvl  (sda_lvl),
        .scl_rise (scl_rise),
        .scl_fall (scl_fall),
        .start_ev (start_ev),
        .stop_ev  (stop_ev)
    );

    tw_protect_decode u_protect (
        .wp_sel   (wp_sel),
        .addr_top (ptr[ADDR_W-1 -: 2]),
        .fenced   (fenced)
    );

    tw_byte_array #(.ADDR_W(ADDR_W)) u_array (
        .clk   (clk),
        .we    (mem_we),
        .addr  (ptr),
        .wdata (rx_sh),
        .rdata (mem_rdata)
    );

    // Purpose: qualify SCL falls that belong to an active transaction.
    always_comb begin
        bus_fall = scl_fall & (phase != PH_IDLE);
        mem_we   = bus_fall & (phase == PH_WDATA) & (bit_cnt == CNT_LAST_DATA) & ~fenced;
    end

    // Purpose: bit counter and receive shifter, advanced on SCL rise.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bit_cnt <= '0;
            rx_sh   <= '0;
            m_ack   <= 1'b0;
        end else if (start_ev || stop_ev) begin
            bit_cnt <= '0;
        end else if (phase != PH_IDLE && scl_rise) begin
            bit_cnt <= bit_cnt + 4'd1;
            m_ack   <= ~sda_lvl;
            if (bit_cnt < CNT_LAST_DATA) begin
                rx_sh <= {rx_sh[6:0], sda_lvl};
            end
        end else if (bus_fall && bit_cnt == CNT_ACK_DONE) begin
            bit_cnt <= '0;
        end
    end

    // Purpose: phase sequencing, pointer update and SDA drive on SCL fall.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase     <= PH_IDLE;
            ptr       <= '0;
            addr_hi   <= '0;
            rd_dir    <= 1'b0;
            tx_sh     <= '0;
            drive_low <= 1'b0;
        end else if (start_ev) begin
            phase     <= PH_DEV;
            drive_low <= 1'b0;
        end else if (stop_ev) begin
            phase     <= PH_IDLE;
            drive_low <= 1'b0;
        end else if (bus_fall) begin
            if (bit_cnt == CNT_LAST_DATA) begin
                // Ninth clock begins: decide the acknowledge.
                unique case (phase)
                    PH_DEV: begin
                        if (rx_sh[7:1] == DEV_ID) begin
                            drive_low <= 1'b1;
                            rd_dir    <= rx_sh[0];
                        end else begin
                            phase <= PH_IDLE;
                        end
                    end
                    PH_AHI: begin
                        addr_hi   <= rx_sh[HI_W-1:0];
                        drive_low <= 1'b1;
                    end
                    PH_ALO: begin
                        ptr       <= {addr_hi, rx_sh};
                        drive_low <= 1'b1;
                    end
                    PH_WDATA: begin
                        if (!fenced) begin
                            ptr       <= ptr + PTR_ONE;
                            drive_low <= 1'b1;
                        end
                    end
                    default: drive_low <= 1'b0;
                endcase
            end else if (bit_cnt == CNT_ACK_DONE) begin
                // Ninth clock ends: move to the next byte.
                unique case (phase)
                    PH_DEV: begin
                        if (rd_dir) begin
                            phase     <= PH_RDATA;
                            tx_sh     <= mem_rdata;
                            drive_low <= ~mem_rdata[7];
                            ptr       <= ptr + PTR_ONE;
                        end else begin
                            phase     <= PH_AHI;
                            drive_low <= 1'b0;
                        end
                    end
                    PH_AHI: begin
                        phase     <= PH_ALO;
                        drive_low <= 1'b0;
                    end
                    PH_ALO: begin
                        phase     <= PH_WDATA;
                        drive_low <= 1'b0;
                    end
                    PH_RDATA: begin
                        if (m_ack) begin
                            tx_sh     <= mem_rdata;
                            drive_low <= ~mem_rdata[7];
                            ptr       <= ptr + PTR_ONE;
                        end else begin
                            phase     <= PH_IDLE;
                            drive_low <= 1'b0;
                        end
                    end
                    default: drive_low <= 1'b0;
                endcase
            end else if (phase == PH_RDATA && bit_cnt != 4'd0) begin
                // Present the next data bit of the byte being sent.
                drive_low <= ~tx_sh[3'd7 - bit_cnt[2:0]];
            end
        end
    end

    assign sda_pull_low = drive_low;

    // R10: SDA drive moves only after SCL was seen low (or a bus condition reset it).
    assert_sda_scl_low_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(drive_low) |-> (!$past(scl_lvl) || $past(start_ev) || $past(stop_ev)));

    // R4 / R5: the pointer only moves on a falling SCL edge.
    assert_ptr_on_fall_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(ptr) |-> $past(scl_fall));

    // R7: no array write under a full fence.
    assert_no_write_full_R7: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> (wp_sel != 2'b11));

    // R7: under the quarter fence the lowest quadrant is never written.
    assert_no_write_quarter_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_we && wp_sel == 2'b01) |-> (ptr[ADDR_W-1 -: 2] != 2'b00));

    // R7: under the half fence the lower half is never written.
    assert_no_write_half_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_we && wp_sel == 2'b10) |-> ptr[ADDR_W-1]);

    // R8: a foreign identifier never draws an acknowledge.
    assert_foreign_nack_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_fall && phase == PH_DEV && bit_cnt == CNT_LAST_DATA && rx_sh[7:1] != DEV_ID)
        |=> !drive_low);

    // R2: the bit counter never passes the acknowledge clock.
    assert_bitcnt_range_R2: assert property (@(posedge clk) disable iff (!rst_n)
        bit_cnt <= CNT_ACK_DONE);

endmodule

// File: tb/tw_mem_slave_tb.sv
// Bench: directed scenarios, one task each, driving a bit-level bus master.
module tw_mem_slave_tb;

    localparam logic [6:0] MEM_ID = 7'h50;
    localparam logic [6:0] CMP_ID = 7'h68;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       scl = 1'b1;
    logic       m_low = 1'b0;
    logic [1:0] wp_sel = 2'b00;
    logic       dut_low;
    logic       sda_bus;

    int n_checks = 0;
    int n_fail   = 0;
    int r10_viol = 0;
    bit finished = 1'b0;
    logic prev_low = 1'b0;
    logic prev_scl = 1'b1;

    always #5 clk = ~clk;

    assign sda_bus = ~(m_low | dut_low);

    tw_mem_slave #(.ADDR_W(9), .DEV_ID(MEM_ID), .SYNC_STAGES(2)) u_dut (
        .clk          (clk),
        .rst_n        (rst_n),
        .scl_i        (scl),
        .sda_i        (sda_bus),
        .sda_pull_low (dut_low),
        .wp_sel       (wp_sel)
    );

    // R10 monitor: slave drive must not change while SCL is held high.
    always @(negedge clk) begin
        if (rst_n && prev_scl && scl && (prev_low !== dut_low)) r10_viol++;
        prev_low <= dut_low;
        prev_scl <= scl;
    end

    task automatic check_eq(input string req, input int act, input int exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic bit_out(input bit b);
        tick(4); m_low = ~b; tick(4); scl = 1'b1; tick(8); scl = 1'b0;
    endtask

    task automatic bit_in(output bit b);
        tick(4); m_low = 1'b0; tick(4); scl = 1'b1; tick(4); b = sda_bus; tick(4); scl = 1'b0;
    endtask

    task automatic send_byte(input logic [7:0] d, output bit ack);
        bit a;
        for (int i = 7; i >= 0; i--) bit_out(d[i]);
        bit_in(a);
        ack = ~a;
    endtask

    task automatic recv_byte(output logic [7:0] d, input bit give_ack);
        bit b;
        for (int i = 7; i >= 0; i--) begin
            bit_in(b);
            d[i] = b;
        end
        bit_out(~give_ack);
    endtask

    task automatic do_start();
        tick(4); m_low = 1'b0; tick(4); scl = 1'b1; tick(8); m_low = 1'b1; tick(8); scl = 1'b0;
    endtask

    task automatic do_stop();
        tick(4); m_low = 1'b1; tick(4); scl = 1'b1; tick(8); m_low = 1'b0; tick(8);
    endtask

    task automatic open_write(input logic [15:0] a, input string req);
        bit ack;
        do_start();
        send_byte({MEM_ID, 1'b0}, ack); check_eq({req, " dev-write ack"}, ack, 1);
        send_byte(a[15:8], ack);        check_eq({req, " addr-hi ack"}, ack, 1);
        send_byte(a[7:0], ack);         check_eq({req, " addr-lo ack"}, ack, 1);
    endtask

    task automatic open_read(input string req);
        bit ack;
        do_start();
        send_byte({MEM_ID, 1'b1}, ack); check_eq({req, " dev-read ack"}, ack, 1);
    endtask

    task automatic put(input logic [7:0] d, input bit exp_ack, input string req);
        bit ack;
        send_byte(d, ack);
        check_eq({req, " data ack"}, ack, exp_ack);
    endtask

    task automatic get(input logic [7:0] exp, input bit last, input string req);
        logic [7:0] d;
        recv_byte(d, ~last);
        check_eq({req, " read data"}, d, exp);
    endtask

    task automatic read_at(input logic [15:0] a, input logic [7:0] exp, input string req);
        open_write(a, req); open_read(req); get(exp, 1'b1, req); do_stop();
    endtask

    task automatic t_reset();
        check_eq("R1 sda released after reset", dut_low, 0);
    endtask

    task automatic t_write_burst();
        open_write(16'h0010, "R3");
        for (int i = 0; i < 5; i++) put(8'h31 + 8'(i), 1'b1, "R4");
        do_stop();
    endtask

    task automatic t_random_read();
        open_write(16'h0010, "R9");
        open_read("R9");
        get(8'h31, 1'b0, "R9");
        get(8'h32, 1'b1, "R5");
        do_stop();
        check_eq("R5 released after master nack", dut_low, 0);
    endtask

    task automatic t_current_read();
        open_read("R5");
        get(8'h33, 1'b1, "R5 current-address");
        do_stop();
    endtask

    task automatic t_foreign_id();
        bit ack;
        do_start();
        send_byte({CMP_ID, 1'b0}, ack); check_eq("R8 foreign write nack", ack, 0);
        send_byte(8'h00, ack);          check_eq("R8 following byte ignored", ack, 0);
        do_stop();
        do_start();
        send_byte({CMP_ID, 1'b1}, ack); check_eq("R8 foreign read nack", ack, 0);
        do_stop();
        open_read("R8");
        get(8'h34, 1'b1, "R8 pointer kept");
        do_stop();
    endtask

    task automatic t_high_addr();
        open_write(16'hFE05, "R3");
        put(8'h3C, 1'b1, "R3");
        do_stop();
        read_at(16'h0005, 8'h3C, "R3 high bits ignored");
    endtask

    task automatic t_wrap();
        open_write(16'h01FF, "R6");
        put(8'h11, 1'b1, "R6");
        put(8'h22, 1'b1, "R6 write wrap");
        do_stop();
        open_write(16'h01FF, "R6");
        open_read("R6");
        get(8'h11, 1'b0, "R6");
        get(8'h22, 1'b1, "R6 read wrap");
        do_stop();
    endtask

    task automatic t_reset_ptr();
        tick(2); rst_n = 1'b0; tick(4); rst_n = 1'b1; tick(4);
        check_eq("R1 sda released after reset pulse", dut_low, 0);
        open_read("R1");
        get(8'h22, 1'b1, "R1 pointer zero");
        do_stop();
    endtask

    task automatic t_protect();
        wp_sel = 2'b00;
        open_write(16'h007F, "R7 prime"); put(8'hAA, 1'b1, "R7"); put(8'hBB, 1'b1, "R7"); do_stop();
        open_write(16'h00FF, "R7 prime"); put(8'hCC, 1'b1, "R7"); put(8'hDD, 1'b1, "R7"); do_stop();
        open_write(16'h01FE, "R7 prime"); put(8'hEE, 1'b1, "R7"); do_stop();

        wp_sel = 2'b01;
        open_write(16'h007F, "R7 quarter"); put(8'h55, 1'b0, "R7 quarter refused"); do_stop();
        open_read("R7"); get(8'hAA, 1'b1, "R7 quarter kept, pointer held"); do_stop();
        open_write(16'h0080, "R7 quarter"); put(8'h66, 1'b1, "R7 above quarter"); do_stop();
        read_at(16'h0080, 8'h66, "R7 above quarter stored");

        wp_sel = 2'b10;
        open_write(16'h00FF, "R7 half"); put(8'h77, 1'b0, "R7 half refused"); do_stop();
        read_at(16'h00FF, 8'hCC, "R7 half kept");
        open_write(16'h0100, "R7 half"); put(8'h88, 1'b1, "R7 above half"); do_stop();
        read_at(16'h0100, 8'h88, "R7 above half stored");

        wp_sel = 2'b11;
        open_write(16'h01FE, "R7 full"); put(8'h99, 1'b0, "R7 full refused"); do_stop();
        read_at(16'h01FE, 8'hEE, "R7 full kept");

        wp_sel = 2'b00;
        open_write(16'h0000, "R7 none"); put(8'h5A, 1'b1, "R7 none accepted"); do_stop();
        read_at(16'h0000, 8'h5A, "R7 none stored");
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog actual=%0h expected=%0h", 1, 0);
        finish_run();
    end

    initial begin
        tick(6);
        rst_n = 1'b1;
        tick(6);
        t_reset();
        t_write_burst();
        t_random_read();
        t_current_read();
        t_foreign_id();
        t_high_addr();
        t_wrap();
        t_reset_ptr();
        t_protect();
        check_eq("R10 drive changes with SCL high", r10_viol, 0);
        finish_run();
    end

endmodule